// File: doc/BRIEF.md
# Start/Stop Interval Counter Controller

This block measures the time between two events by counting cycles of its clock. One trigger line is picked as the start source and another (or the same one) as the stop source, each with its own edge polarity. After an arm command the controller waits for the start edge. It then counts until the stop edge and latches the final count into a read-only result register.

An optional skip counter lets a measurement span several stop edges, for example several periods of a signal. An optional saturation limit ends a measurement that would otherwise run forever, and flags it. Configuration is frozen while a measurement is in progress. Software reaches everything through a small register bus: synchronous write strobe, combinational read.

Register map (3-bit address, 32-bit data):
- 0: trigger setup. Bits [2:0] start source, bit 3 start polarity, bits [6:4] stop source, bit 7 stop polarity. Polarity 0 is rising, 1 is falling.
- 1: skip count, bits [7:0].
- 2: mode. Bit 0 enables the skip counter, bit 1 enables saturation.
- 3: saturation limit.
- 4: command, write only. Bit 0 arms, bit 1 aborts.
- 5: status. Bit 0 done, bit 1 saturated, bit 2 waiting for start, bit 3 counting.
- 6: result.

Top module: `interval_ctl`

## Requirements
- R1: After reset the controller is idle, and registers 0, 1, 2, 3, 5 and 6 read as zero.
- R2: Writes to registers 0 to 3 take effect only while the controller is idle (status bits 2 and 3 both clear). Writes at any other time leave the readback unchanged.
- R3: The start and stop events are the edges, of the programmed polarity, on the trigger lines selected in register 0. Trigger lines pass through a two-flop synchronizer.
- R4: If the start line changes just before clock edge a and the stop line changes just before clock edge b, the result is b - a.
- R5: With mode bit 0 set, the first N qualifying stop edges after the start are skipped, where N is the value in register 1, and the measurement ends on edge N+1. With mode bit 0 clear, the first qualifying stop edge ends it, whatever register 1 holds.
- R6: With mode bit 1 set, the measurement ends once the count exceeds the limit. The result is then limit+1, and status reads 3 (saturated and done).
- R7: With saturation disabled, the count holds at its all-ones value instead of wrapping.
- R8: A normal stop sets done and leaves saturated clear. The result holds until the next arm, and arm clears the result and both flags.
- R9: An abort while waiting or counting returns to idle with done clear. An abort while idle changes neither status nor result.
- R10: An arm command outside idle is ignored. Stop edges seen while waiting for the start edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| trig_i | input | NTRIG | Candidate trigger lines |

## Verification
The bench walks a table of source and polarity pairs, including one line used for both start and stop, and checks the exact cycle count. An off-by-one in the synchronizer or edge path shows up as a result one cycle off.

Directed cases cover the following:
- A stop edge sent before the start, which a design ignoring arm-state gating would accept as an early stop.
- A second arm sent mid-count, which a design that restarts on it would shorten.
- Config writes while armed, which would show up in the readback if not blocked.
- A skip count both with and without its enable bit, which catches a design that ignores the enable.
- Saturation, where a wrong comparison gives a result other than limit+1.
- A long run with saturation off, which exposes a counter that wraps.

// File: rtl/interval_pkg.sv
package interval_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } ctl_state_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_TRIG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SKIP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd6;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned NTRIG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_i,
  output logic [NTRIG-1:0] rise_o,
  output logic [NTRIG-1:0] fall_o
);
  for (genvar i = 0; i < NTRIG; i++) begin : g_line
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= trig_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[i] = sync_q & ~prev_q;
    assign fall_o[i] = ~sync_q & prev_q;

    // R3: a detected edge lasts exactly one cycle
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/interval_regs.sv
module interval_regs
  import interval_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned SKIP_W    = 8,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned TRIG_W   = 2 * SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_low,
  input  logic              cfg_open,
  output logic [TRIG_W-1:0] trig_cfg,
  output logic [SKIP_W-1:0] skip_cfg,
  output logic [1:0]        mode_cfg,
  output logic [CNT_W-1:0]  limit_cfg
);
  logic we_trig, we_skip, we_mode, we_limit;

  assign we_trig  = wr_en && cfg_open && (wr_addr == A_TRIG);
  assign we_skip  = wr_en && cfg_open && (wr_addr == A_SKIP);
  assign we_mode  = wr_en && cfg_open && (wr_addr == A_MODE);
  assign we_limit = wr_en && cfg_open && (wr_addr == A_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_cfg  <= '0;
      skip_cfg  <= '0;
      mode_cfg  <= '0;
      limit_cfg <= '0;
    end else begin
      if (we_trig)  trig_cfg  <= wr_low[TRIG_W-1:0];
      if (we_skip)  skip_cfg  <= wr_low[SKIP_W-1:0];
      if (we_mode)  mode_cfg  <= wr_low[1:0];
      if (we_limit) limit_cfg <= wr_low;
    end
  end

  // R2: configuration frozen outside idle
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable({trig_cfg, skip_cfg, mode_cfg, limit_cfg}));
endmodule

// File: rtl/interval_fsm.sv
module interval_fsm
  import interval_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              skip_en,
  input  logic [SKIP_W-1:0] skip_load,
  input  logic              sat_en,
  input  logic [CNT_W-1:0]  sat_limit,
  output ctl_state_e        state_o,
  output logic              done_o,
  output logic              sat_o,
  output logic [CNT_W-1:0]  result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctl_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              done_q, done_d, sat_q, sat_d;
  logic [CNT_W-1:0]  res_q, res_d;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    skip_d  = skip_q;
    done_d  = done_q;
    sat_d   = sat_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (arm) begin
          state_d = ST_ARMED;
          done_d  = 1'b0;
          sat_d   = 1'b0;
          res_d   = '0;
          skip_d  = skip_load;
        end
      end
      ST_ARMED: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (start_ev) begin
          state_d = ST_COUNT;
          cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
        end
      end
      ST_COUNT: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (sat_en && (cnt_q > sat_limit)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          sat_d   = 1'b1;
          res_d   = cnt_q;
        end else if (stop_ev && skip_en && (skip_q != '0)) begin
          skip_d = skip_q - 1'b1;
          cnt_d  = cnt_inc;
        end else if (stop_ev) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          res_d   = cnt_q;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      skip_q  <= '0;
      done_q  <= 1'b0;
      sat_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      skip_q  <= skip_d;
      done_q  <= done_d;
      sat_q   <= sat_d;
      res_q   <= res_d;
    end
  end

  assign state_o  = state_q;
  assign done_o   = done_q;
  assign sat_o    = sat_q;
  assign result_o = res_q;

  // R6: saturation always reported together with done
  a_r6_sat_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> done_q);
  // R9: abort from an active state lands in idle without done
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && state_q != ST_IDLE) |=> (state_q == ST_IDLE && !done_q));
  // R7: counter never wraps from all ones
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R8: done only rises at the end of counting
  a_r8_done_from_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == ST_COUNT));
  // R8: result held in idle until an arm
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm) |=> $stable(res_q));
endmodule

// File: rtl/interval_ctl.sv
module interval_ctl
  import interval_pkg::*;
#(
  parameter int unsigned NTRIG  = 8,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SKIP_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NTRIG-1:0]  trig_i
);
  localparam int unsigned SEL_W  = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam int unsigned TRIG_W = 2 * SEL_W + 2;

  logic [NTRIG-1:0]  rise_v, fall_v;
  logic [TRIG_W-1:0] trig_cfg;
  logic [SKIP_W-1:0] skip_cfg;
  logic [1:0]        mode_cfg;
  logic [CNT_W-1:0]  limit_cfg;
  ctl_state_e        state;
  logic              done, sat;
  logic [CNT_W-1:0]  result;
  logic [SEL_W-1:0]  start_sel, stop_sel;
  logic              start_pol, stop_pol;
  logic              start_ev, stop_ev, cmd_wr, arm, abort;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

  trig_edge_sync #(.NTRIG(NTRIG)) i_sync (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .rise_o(rise_v), .fall_o(fall_v)
  );

  interval_regs #(.SEL_W(SEL_W), .SKIP_W(SKIP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_low(wr_data[CNT_W-1:0]), .cfg_open(state == ST_IDLE),
    .trig_cfg(trig_cfg), .skip_cfg(skip_cfg), .mode_cfg(mode_cfg), .limit_cfg(limit_cfg)
  );

  assign start_sel = trig_cfg[SEL_W-1:0];
  assign start_pol = trig_cfg[SEL_W];
  assign stop_sel  = trig_cfg[2*SEL_W:SEL_W+1];
  assign stop_pol  = trig_cfg[2*SEL_W+1];
  assign start_ev  = start_pol ? fall_v[start_sel] : rise_v[start_sel];
  assign stop_ev   = stop_pol  ? fall_v[stop_sel]  : rise_v[stop_sel];

  assign cmd_wr = wr_en && (wr_addr == A_CMD);
  assign arm    = cmd_wr && wr_data[0];
  assign abort  = cmd_wr && wr_data[1];

  interval_fsm #(.CNT_W(CNT_W), .SKIP_W(SKIP_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .skip_en(mode_cfg[0]), .skip_load(skip_cfg),
    .sat_en(mode_cfg[1]), .sat_limit(limit_cfg),
    .state_o(state), .done_o(done), .sat_o(sat), .result_o(result)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_TRIG:   rd_data = DATA_W'(trig_cfg);
      A_SKIP:   rd_data = DATA_W'(skip_cfg);
      A_MODE:   rd_data = DATA_W'(mode_cfg);
      A_LIMIT:  rd_data = DATA_W'(limit_cfg);
      A_STATUS: rd_data = DATA_W'({state == ST_COUNT, state == ST_ARMED, sat, done});
      A_RESULT: rd_data = DATA_W'(result);
      default:  rd_data = '0;
    endcase
  end

  // R10: a repeated arm cannot push an active measurement back to waiting
  a_r10_arm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !abort && state == ST_COUNT) |=> (state != ST_ARMED));
endmodule

// File: tb/test_interval_ctl.sv
module test_interval_ctl;
  localparam int CW = 12;

  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, v;
  logic [7:0]  trig;
  int checks = 0, errors = 0;
  bit finished = 0;

  interval_ctl #(.NTRIG(8), .CNT_W(CW), .SKIP_W(8), .DATA_W(32)) i_interval_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_i(trig)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // rows: [15:13] start src, [12] start pol, [11:9] stop src, [8] stop pol, [7:0] gap
  localparam logic [15:0] VEC [4] = '{
    {3'd0, 1'b0, 3'd1, 1'b0, 8'd9},
    {3'd2, 1'b1, 3'd5, 1'b0, 8'd17},
    {3'd3, 1'b0, 3'd3, 1'b1, 8'd6},
    {3'd7, 1'b1, 3'd4, 1'b1, 8'd30}
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; trig = 0;
    wait_n(3); rst_n = 1; wait_n(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      if (a != 4) begin rd(a[2:0], v); chk("R1 reset readback", v, 0); end
    end

    // R3 R4 R8 table walk
    for (int i = 0; i < 4; i++) begin
      logic [2:0] ss, ps; logic sp, pp; int gap;
      ss = VEC[i][15:13]; sp = VEC[i][12]; ps = VEC[i][11:9]; pp = VEC[i][8]; gap = int'(VEC[i][7:0]);
      trig = 0; trig[ps] = pp; trig[ss] = sp;
      wait_n(5);
      wr(3'd0, {24'd0, pp, ps, sp, ss});
      wr(3'd2, 0);
      wr(3'd4, 1);
      wait_n(2);
      trig[ss] = ~sp;
      wait_n(gap);
      trig[ps] = ~pp;
      wait_n(5);
      rd(3'd5, v); chk("R8 done without sat", v, 1);
      rd(3'd6, v); chk("R4 R3 interval count", v, gap);
    end

    // R8 result held in idle, then cleared by arm
    wait_n(10);
    rd(3'd6, v); chk("R8 result held", v, 30);
    trig = 0; wait_n(5);
    wr(3'd0, 32'h10);                 // start line0 rising, stop line1 rising
    wr(3'd4, 1); wait_n(1);
    rd(3'd5, v); chk("R8 arm clears flags", v, 4);
    rd(3'd6, v); chk("R8 arm clears result", v, 0);

    // R2 writes ignored while armed
    wr(3'd0, 32'hFF); wr(3'd3, 32'd77);
    rd(3'd0, v); chk("R2 trig ignored", v, 32'h10);
    rd(3'd3, v); chk("R2 limit ignored", v, 0);

    // R9 abort from armed
    wr(3'd4, 2); wait_n(1);
    rd(3'd5, v); chk("R9 abort armed", v, 0);

    // R10 stop edge before start ignored
    wr(3'd4, 1); wait_n(1);
    trig[1] = 1; wait_n(4);
    rd(3'd5, v); chk("R10 early stop ignored", v, 4);
    trig[0] = 1; wait_n(3); trig[1] = 0; wait_n(4); trig[1] = 1;
    wait_n(5);
    rd(3'd6, v); chk("R10 result after early stop", v, 7);

    // R10 arm while counting ignored
    trig = 0; wait_n(5);
    wr(3'd4, 1); wait_n(2);
    trig[0] = 1; wait_n(5);
    wr(3'd4, 1);
    wait_n(4); trig[1] = 1; wait_n(5);
    rd(3'd6, v); chk("R10 rearm ignored", v, 10);

    // R9 abort while counting
    trig = 0; wait_n(5);
    wr(3'd4, 1); wait_n(2); trig[0] = 1; wait_n(6);
    rd(3'd5, v); chk("R9 counting seen", v, 8);
    wr(3'd4, 2); wait_n(1);
    rd(3'd5, v); chk("R9 abort counting", v, 0);
    rd(3'd6, v); chk("R9 result after abort", v, 0);

    // R5 skip two stop edges
    trig = 0; wait_n(5);
    wr(3'd1, 2); wr(3'd2, 1);
    rd(3'd1, v); chk("R2 idle write accepted", v, 2);
    wr(3'd4, 1); wait_n(2); trig[0] = 1;
    for (int k = 0; k < 3; k++) begin
      wait_n(5); trig[1] = 1; wait_n(3); trig[1] = 0;
    end
    wait_n(5);
    rd(3'd6, v); chk("R5 skip count", v, 21);
    rd(3'd5, v); chk("R5 skip done", v, 1);

    // R5 skip value ignored without enable
    trig = 0; wait_n(5);
    wr(3'd2, 0);
    wr(3'd4, 1); wait_n(2); trig[0] = 1;
    wait_n(5); trig[1] = 1; wait_n(3); trig[1] = 0;
    wait_n(20);
    rd(3'd6, v); chk("R5 skip disabled", v, 5);

    // R6 saturation
    trig = 0; wait_n(5);
    wr(3'd3, 20); wr(3'd2, 2);
    wr(3'd4, 1); wait_n(2); trig[0] = 1;
    wait_n(40);
    rd(3'd5, v); chk("R6 sat and done", v, 3);
    rd(3'd6, v); chk("R6 sat result", v, 21);

    // R9 abort in idle has no effect
    wr(3'd4, 2); wait_n(1);
    rd(3'd5, v); chk("R9 idle abort status", v, 3);
    rd(3'd6, v); chk("R9 idle abort result", v, 21);

    // R7 hold at maximum without saturation
    trig = 0; wait_n(5);
    wr(3'd2, 0);
    wr(3'd4, 1); wait_n(2); trig[0] = 1;
    wait_n(4200);
    rd(3'd5, v); chk("R7 still counting", v, 8);
    trig[1] = 1; wait_n(5);
    rd(3'd6, v); chk("R7 holds at max", v, (1 << CW) - 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule